// File: doc/BRIEF.md
# Multichannel voice codec command controller

This block controls a group of four voice codec channels. Command bytes arrive one per clock with a strobe, and each byte carries a 2-bit channel tag. The block decodes each byte and places the tagged channel in standby or active mode. It performs a reset of one channel or of the whole group, and it gives write and read access to one 8-bit operating-conditions register per channel. A write takes two bytes: the command byte `70h`, then the data byte on the next strobe. The data byte is stored in the channel that was tagged with the command, whatever tag the data byte carries. A read (`71h`) returns the register on a response port.

Each channel drives a status bit and a bias-enable bit. Both reflect the channel's mode. Each channel also drives a B-channel data-valid flag. This flag is gated by frame-sync pulses, so data is marked valid only after a settling period following activation. A 4-bit ground-key filter interval is shared by the group. It has its own write strobe, survives a per-channel reset, and is cleared only by a group reset.

Top module: `vcodec_cmd_ctrl`

## Requirements
- R1: After rst_ni is released, every status, bias and data-valid bit is 0, the interval register reads 0, no response is strobed, and every operating-conditions register reads 04h.
- R2: Command byte 0Eh sets the tagged channel's status and bias bits to 1 on the cycle after the byte is accepted. Other channels keep their state.
- R3: After an activate from standby, the channel's data-valid bit rises on the cycle after the second frame-sync pulse that is sampled after the command. A pulse in the same cycle as the command is not counted. Data-valid is never 1 while status is 0.
- R4: Command byte 00h clears the tagged channel's status, bias and data-valid bits and keeps its operating-conditions register.
- R5: Byte 70h followed by a data byte writes that data to the channel tagged with 70h. Byte 71h produces a one-cycle response strobe on the next cycle, with the register value and the channel tag. Both work in standby.
- R6: Command byte 02h returns only the tagged channel to standby, sets its register to 04h and restarts its frame-sync count. The interval register and the other channels are unchanged.
- R7: Command byte 04h returns all channels to standby, sets all registers to 04h and clears the interval register.
- R8: Any command byte other than 00h, 02h, 04h, 0Eh, 70h or 71h changes no output and no register.
- R9: A repeated 0Eh to a channel that is already active leaves its data-valid bit as it is and does not restart its frame-sync count.
- R10: gk_we_i loads gk_data_i into the interval register. A group reset in the same cycle takes priority and leaves it 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | Command or data byte strobe |
| cmd_byte_i | input | 8 | Command or data byte |
| cmd_chan_i | input | 2 | Target channel tag |
| frame_sync_i | input | 1 | Frame-sync pulse |
| gk_we_i | input | 1 | Interval register write strobe |
| gk_data_i | input | 4 | Interval write data |
| rsp_valid_o | output | 1 | One-cycle read response strobe |
| rsp_data_o | output | 8 | Read response data |
| rsp_chan_o | output | 2 | Channel of the read response |
| chan_status_o | output | 4 | Per-channel status bit (1 = active) |
| bias_en_o | output | 4 | Per-channel analog bias enable |
| bdata_valid_o | output | 4 | Per-channel B-channel data valid |
| gk_interval_o | output | 4 | Shared ground-key filter interval |

## Verification
A frame-sync counter that is off by one shows up at bdata_valid_o one pulse too early or one pulse too late, within a few cycles of the second pulse. A reset that reaches the wrong scope shows on the next cycle: another channel's status bit drops, or gk_interval_o changes. Register contents and a stuck write-pending state are only visible through a later read response, one cycle after the 71h byte. A write-pending state that is stuck also turns the next command into data, so the status bits stop following the commands. Every byte value is swept, with frame-sync pulses interleaved, against a model of the bench's own. All four channels are read back afterwards.

// File: rtl/vcodec_cmd_pkg.sv
package vcodec_cmd_pkg;
  typedef enum logic [2:0] {
    OP_NONE, OP_STBY, OP_SRST, OP_HRST, OP_ACT, OP_WR, OP_RD
  } cmd_op_e;

  localparam logic [7:0] CMD_STBY = 8'h00;
  localparam logic [7:0] CMD_SRST = 8'h02;
  localparam logic [7:0] CMD_HRST = 8'h04;
  localparam logic [7:0] CMD_ACT  = 8'h0E;
  localparam logic [6:0] CMD_CFG  = 7'b0111000;  // LSB: 0 write, 1 read
  localparam logic [7:0] CFG_RST  = 8'h04;
endpackage

// File: rtl/vcodec_cmd_dec.sv
module vcodec_cmd_dec
  import vcodec_cmd_pkg::*;
(
  input  logic [7:0] cmd_i,
  output cmd_op_e    op_o
);
  always_comb begin
    op_o = OP_NONE;
    if (cmd_i[7:1] == CMD_CFG) op_o = cmd_i[0] ? OP_RD : OP_WR;
    else begin
      case (cmd_i)
        CMD_STBY: op_o = OP_STBY;
        CMD_SRST: op_o = OP_SRST;
        CMD_HRST: op_o = OP_HRST;
        CMD_ACT:  op_o = OP_ACT;
        default:  op_o = OP_NONE;
      endcase
    end
  end
endmodule

// File: rtl/vcodec_chan.sv
module vcodec_chan
  import vcodec_cmd_pkg::*;
#(
  parameter int FS_WAIT = 2,
  parameter int CFG_W   = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             stby_i,
  input  logic             act_i,
  input  logic             srst_i,
  input  logic             hrst_i,
  input  logic             cfg_we_i,
  input  logic [CFG_W-1:0] cfg_d_i,
  input  logic             fs_i,
  output logic             active_o,
  output logic             bvalid_o,
  output logic [CFG_W-1:0] cfg_o
);
  localparam int CNT_W = $clog2(FS_WAIT + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(FS_WAIT - 1);

  logic [CNT_W-1:0] fs_cnt_q;
  logic             rst_any;

  assign rst_any = srst_i | hrst_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_o <= 1'b0;
      bvalid_o <= 1'b0;
      fs_cnt_q <= '0;
      cfg_o    <= CFG_W'(CFG_RST);
    end else if (rst_any) begin
      active_o <= 1'b0;
      bvalid_o <= 1'b0;
      fs_cnt_q <= '0;
      cfg_o    <= CFG_W'(CFG_RST);
    end else begin
      if (cfg_we_i) cfg_o <= cfg_d_i;
      if (stby_i) begin
        active_o <= 1'b0;
        bvalid_o <= 1'b0;
        fs_cnt_q <= '0;
      end else if (act_i && !active_o) begin
        active_o <= 1'b1;
        bvalid_o <= 1'b0;
        fs_cnt_q <= '0;
      end else if (fs_i && active_o && !bvalid_o) begin
        // a repeated activate falls through here, so counting continues
        if (fs_cnt_q == CNT_LAST) bvalid_o <= 1'b1;
        fs_cnt_q <= fs_cnt_q + 1'b1;
      end
    end
  end

  p_act_status_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act_i && !stby_i && !rst_any) |=> active_o);
  p_valid_on_fs_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(bvalid_o) |-> $past(fs_i));
  p_stby_clear_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stby_i && !rst_any) |=> (!active_o && !bvalid_o));
  p_reset_chan_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_any |=> (cfg_o == CFG_W'(CFG_RST) && !active_o && !bvalid_o));
  p_reactivate_keep_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act_i && bvalid_o && !stby_i && !rst_any) |=> bvalid_o);
endmodule

// File: rtl/vcodec_cmd_ctrl.sv
module vcodec_cmd_ctrl
  import vcodec_cmd_pkg::*;
#(
  parameter int NUM_CH  = 4,
  parameter int GK_W    = 4,
  parameter int FS_WAIT = 2,
  localparam int CH_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_valid_i,
  input  logic [7:0]        cmd_byte_i,
  input  logic [CH_W-1:0]   cmd_chan_i,
  input  logic              frame_sync_i,
  input  logic              gk_we_i,
  input  logic [GK_W-1:0]   gk_data_i,
  output logic              rsp_valid_o,
  output logic [7:0]        rsp_data_o,
  output logic [CH_W-1:0]   rsp_chan_o,
  output logic [NUM_CH-1:0] chan_status_o,
  output logic [NUM_CH-1:0] bias_en_o,
  output logic [NUM_CH-1:0] bdata_valid_o,
  output logic [GK_W-1:0]   gk_interval_o
);
  cmd_op_e         dec_op;
  cmd_op_e         op_eff;
  logic            wr_pend_q;
  logic [CH_W-1:0] wr_ch_q;
  logic            cfg_we;
  logic            hrst;
  logic [7:0]      cfg_q [NUM_CH];

  vcodec_cmd_dec u_dec (
    .cmd_i (cmd_byte_i),
    .op_o  (dec_op)
  );

  // byte after a write command is data, never a command
  assign op_eff = (cmd_valid_i && !wr_pend_q) ? dec_op : OP_NONE;
  assign cfg_we = cmd_valid_i && wr_pend_q;
  assign hrst   = (op_eff == OP_HRST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_pend_q <= 1'b0;
      wr_ch_q   <= '0;
    end else if (cfg_we) begin
      wr_pend_q <= 1'b0;
    end else if (op_eff == OP_WR) begin
      wr_pend_q <= 1'b1;
      wr_ch_q   <= cmd_chan_i;
    end
  end

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chan
    logic sel;
    assign sel = (cmd_chan_i == CH_W'(ch));

    vcodec_chan #(
      .FS_WAIT (FS_WAIT),
      .CFG_W   (8)
    ) u_chan (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .stby_i   (sel && op_eff == OP_STBY),
      .act_i    (sel && op_eff == OP_ACT),
      .srst_i   (sel && op_eff == OP_SRST),
      .hrst_i   (hrst),
      .cfg_we_i (cfg_we && wr_ch_q == CH_W'(ch)),
      .cfg_d_i  (cmd_byte_i),
      .fs_i     (frame_sync_i),
      .active_o (chan_status_o[ch]),
      .bvalid_o (bdata_valid_o[ch]),
      .cfg_o    (cfg_q[ch])
    );
    assign bias_en_o[ch] = chan_status_o[ch];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o <= 1'b0;
      rsp_data_o  <= '0;
      rsp_chan_o  <= '0;
    end else begin
      rsp_valid_o <= (op_eff == OP_RD);
      if (op_eff == OP_RD) begin
        rsp_data_o <= cfg_q[cmd_chan_i];
        rsp_chan_o <= cmd_chan_i;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      gk_interval_o <= '0;
    else if (hrst)    gk_interval_o <= '0;
    else if (gk_we_i) gk_interval_o <= gk_data_i;
  end

  p_rsp_from_read_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> $past(cmd_valid_i && !wr_pend_q && cmd_byte_i == {CMD_CFG, 1'b1}));
  p_valid_needs_status_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bdata_valid_o & ~chan_status_o) == '0);
  p_hrst_all_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hrst |=> (gk_interval_o == '0 && chan_status_o == '0));
  p_gk_write_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gk_we_i && !hrst) |=> gk_interval_o == $past(gk_data_i));
endmodule

// File: tb/vcodec_cmd_ctrl_tb.sv
module vcodec_cmd_ctrl_tb;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       cmd_valid_i = 1'b0;
  logic [7:0] cmd_byte_i = '0;
  logic [1:0] cmd_chan_i = '0;
  logic       frame_sync_i = 1'b0;
  logic       gk_we_i = 1'b0;
  logic [3:0] gk_data_i = '0;
  logic       rsp_valid_o;
  logic [7:0] rsp_data_o;
  logic [1:0] rsp_chan_o;
  logic [3:0] chan_status_o, bias_en_o, bdata_valid_o, gk_interval_o;

  int total = 0, bad = 0;
  bit done = 0;

  // bench model
  bit         m_act [4];
  bit         m_val [4];
  int         m_cnt [4];
  logic [7:0] m_cfg [4];
  logic [3:0] m_gk;
  bit         m_pend;
  logic [1:0] m_pch;
  bit         m_rv;
  logic [7:0] m_rd;
  logic [1:0] m_rc;

  always #10 clk = ~clk;

  vcodec_cmd_ctrl u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .cmd_valid_i(cmd_valid_i), .cmd_byte_i(cmd_byte_i),
    .cmd_chan_i(cmd_chan_i), .frame_sync_i(frame_sync_i), .gk_we_i(gk_we_i),
    .gk_data_i(gk_data_i), .rsp_valid_o(rsp_valid_o), .rsp_data_o(rsp_data_o),
    .rsp_chan_o(rsp_chan_o), .chan_status_o(chan_status_o), .bias_en_o(bias_en_o),
    .bdata_valid_o(bdata_valid_o), .gk_interval_o(gk_interval_o)
  );

  task automatic chk(input string tag, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h t=%0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic m_reset_ch(input int i);
    m_act[i] = 0; m_val[i] = 0; m_cnt[i] = 0; m_cfg[i] = 8'h04;
  endtask

  task automatic model(input logic cv, input logic [7:0] b, input logic [1:0] ch,
                       input logic fs, input logic gwe, input logic [3:0] gd);
    m_rv = 0;
    if (gwe) m_gk = gd;
    for (int i = 0; i < 4; i++)
      if (fs && m_act[i] && !m_val[i]) begin
        m_cnt[i]++;
        if (m_cnt[i] == 2) m_val[i] = 1;
      end
    if (cv) begin
      if (m_pend) begin
        m_cfg[m_pch] = b; m_pend = 0;
      end else begin
        case (b)
          8'h00: begin m_act[ch] = 0; m_val[ch] = 0; m_cnt[ch] = 0; end
          8'h02: m_reset_ch(ch);
          8'h04: begin for (int i = 0; i < 4; i++) m_reset_ch(i); m_gk = 0; end
          8'h0E: if (!m_act[ch]) begin m_act[ch] = 1; m_val[ch] = 0; m_cnt[ch] = 0; end
          8'h70: begin m_pend = 1; m_pch = ch; end
          8'h71: begin m_rv = 1; m_rd = m_cfg[ch]; m_rc = ch; end
          default: ;
        endcase
      end
    end
  endtask

  task automatic check_all(input string tag);
    for (int i = 0; i < 4; i++) begin
      chk(tag, $sformatf("status[%0d]", i), chan_status_o[i], m_act[i]);
      chk(tag, $sformatf("bias[%0d]", i), bias_en_o[i], m_act[i]);
      chk(tag, $sformatf("bvalid[%0d]", i), bdata_valid_o[i], m_val[i]);
    end
    chk(tag, "gk", gk_interval_o, m_gk);
    chk(tag, "rsp_valid", rsp_valid_o, m_rv);
    if (m_rv) begin
      chk(tag, "rsp_data", rsp_data_o, m_rd);
      chk(tag, "rsp_chan", rsp_chan_o, m_rc);
    end
  endtask

  // drive at a falling edge, check at the next falling edge
  task automatic cyc(input string tag, input logic cv, input logic [7:0] b, input logic [1:0] ch,
                     input logic fs = 0, input logic gwe = 0, input logic [3:0] gd = 0);
    cmd_valid_i = cv; cmd_byte_i = b; cmd_chan_i = ch;
    frame_sync_i = fs; gk_we_i = gwe; gk_data_i = gd;
    model(cv, b, ch, fs, gwe, gd);
    @(negedge clk);
    check_all(tag);
    cmd_valid_i = 0; frame_sync_i = 0; gk_we_i = 0;
  endtask

  task automatic idle(input string tag, input logic fs = 0);
    cyc(tag, 0, 8'h00, 0, fs);
  endtask

  task automatic rd(input string tag, input logic [1:0] ch);
    cyc(tag, 1, 8'h71, ch);
    idle(tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 4; i++) m_reset_ch(i);
    m_gk = 0; m_pend = 0; m_pch = 0; m_rv = 0; m_rd = 0; m_rc = 0;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    check_all("R1");
    for (int c = 0; c < 4; c++) rd("R1", 2'(c));

    // R3: pulse in activate cycle not counted, valid after second later pulse
    cyc("R2", 1, 8'h0E, 1, 1);
    chk("R3", "bvalid1 after act", bdata_valid_o[1], 0);
    idle("R3", 1);
    chk("R3", "bvalid1 after fs1", bdata_valid_o[1], 0);
    idle("R3");
    idle("R3", 1);
    chk("R3", "bvalid1 after fs2", bdata_valid_o[1], 1);
    // R9: repeated activate keeps valid
    cyc("R9", 1, 8'h0E, 1, 1);
    chk("R9", "bvalid1 kept", bdata_valid_o[1], 1);
    // R9: reactivate between pulses does not restart count
    cyc("R2", 1, 8'h0E, 3);
    idle("R9", 1);
    cyc("R9", 1, 8'h0E, 3);
    idle("R9", 1);
    chk("R9", "bvalid3 no restart", bdata_valid_o[3], 1);

    // R4/R5: write in standby, standby keeps register
    cyc("R5", 1, 8'h70, 2);
    cyc("R5", 1, 8'h0E, 0);  // data byte, tag ignored
    cyc("R2", 1, 8'h0E, 2);
    cyc("R4", 1, 8'h00, 2);
    rd("R4", 2);
    chk("R4", "cfg2 retained", rsp_data_o, 8'h0E);

    // R6: software reset of one channel
    cyc("R10", 0, 8'h00, 0, 0, 1, 4'h9);
    cyc("R2", 1, 8'h0E, 0);
    cyc("R5", 1, 8'h70, 0);
    cyc("R5", 1, 8'h3C, 3);
    cyc("R6", 1, 8'h02, 0);
    chk("R6", "gk kept", gk_interval_o, 4'h9);
    rd("R6", 0);
    rd("R6", 2);

    // R7/R10: group reset wins over interval write
    cyc("R10", 1, 8'h04, 1, 0, 1, 4'h6);
    chk("R7", "gk cleared", gk_interval_o, 0);
    for (int c = 0; c < 4; c++) rd("R7", 2'(c));
    cyc("R10", 0, 8'h00, 0, 0, 1, 4'hF);

    // R8: sweep every byte value over rotating channels with frame syncs
    for (int c = 0; c < 4; c++) begin
      cyc("R2", 1, 8'h0E, 2'(c));
      cyc("R5", 1, 8'h70, 2'(c));
      cyc("R5", 1, 8'(8'h11 * (c + 3)), 2'(c));
    end
    for (int b = 0; b < 256; b++) begin
      if (b == 8'h04) continue;
      cyc("R8", 1, 8'(b), 2'(b % 4), (b % 3) == 0);
      if (b == 8'h70) cyc("R5", 1, 8'(b ^ 8'h5A), 2'(b % 4));
      idle("R8", (b % 5) == 0);
    end
    for (int c = 0; c < 4; c++) rd("R8", 2'(c));
    cyc("R7", 1, 8'h04, 2);
    for (int c = 0; c < 4; c++) rd("R7", 2'(c));

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule